// File: doc/BRIEF.md
# Level-Mapped Interrupt Controller

This block gathers eight level-sensitive interrupt request lines and turns them into processor priority levels. Each request line that has a meaningful level gets a pending bit that simply mirrors the line. Every pending bit is then sent through a fixed, non-linear lookup to one of sixteen priority levels. The block drives a 16-bit vector with one bit per level, and a 4-bit code that names the highest level currently asserted.

Software controls the block through one byte-wide control register on a simple write/read bus. Bit 0 of that register is a global enable. When it is clear, every level output is held low, but the pending bits keep following their lines. Bit 6 of the register cannot be written and always reads as zero. The other bits are stored and read back, and they have no other effect.

All outputs are registered. A change on a request line, or a register write, shows up at the outputs on the first rising clock edge after the change.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x01, the pending status is 0x00, the level vector is 0x0000 and the highest-level code is 0.
- R2: A register write stores the write data ANDed with 0xBF, so bit 6 of the read data is always 0. The read data shows the stored value from the edge that performs the write onward.
- R3: The pending bit of a mapped source (bit position equals source number) equals that source line as sampled at the previous rising edge. It sets while the line is high and clears once it is low.
- R4: Sources 0 and 6 map to level 0. Their pending bits always read 0, and they never set any bit of the level vector.
- R5: Source 1 drives level 1, source 2 drives level 4, source 3 drives level 6, source 4 drives level 8, source 5 drives level 10 and source 7 drives level 14. Level n is bit n of the level vector.
- R6: With the enable set, a level-vector bit is 1 exactly when at least one pending source maps to that level. Several active sources produce the OR of their level bits.
- R7: When control bit 0 is 0, all sixteen level outputs are 0 and the highest-level code is 0, while the pending status keeps following the source lines.
- R8: The highest-level code equals the index of the most significant set bit of the level vector, or 0 when the vector is all zero.
- R9: A write that changes the enable bit takes effect on the level vector at the same edge that stores the new register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| srcIrq | input | 8 | Level-sensitive request lines, bit n is source n |
| busWrEn | input | 1 | Control register write strobe for one cycle |
| busWrData | input | 8 | Data to write into the control register |
| busRdData | output | 8 | Current control register contents |
| pendStatus | output | 8 | Pending bit of each source |
| levelOut | output | 16 | One output per priority level |
| topLevel | output | 4 | Index of the highest asserted level, 0 if none |

## Verification
The hardest case to reach is a register write that flips the enable bit in the same cycle that the sources already hold a non-zero pattern. The level vector must then follow the newly written bit, not the stored one. The bench holds all sources high while the enable is clear, checks that the pending bits still follow the lines while the outputs stay dark, and then re-enables with a single write. It samples the very next edge to confirm that the full level pattern appears at once. A table of single-source and mixed-source patterns covers each mapping, including the two ignored sources alone and mixed with live ones.

// File: rtl/irqmap_pkg.sv
package irqmap_pkg;
  localparam int NUM_SRC   = 8;
  localparam int NUM_LVL   = 16;
  localparam int LVL_W     = $clog2(NUM_LVL);
  localparam int REG_W     = 8;
  localparam logic [REG_W-1:0] WR_MASK   = 8'hBF;
  localparam logic [REG_W-1:0] RESET_VAL = 8'h01;
  localparam int EN_BIT    = 0;

  typedef struct packed {
    logic wrStrobe;
    logic wrEnable;
    logic curEnable;
  } ctrlStrobe_t;

  // Fixed source-to-level lookup; level 0 marks an unused source.
  function automatic logic [LVL_W-1:0] srcLevel(input int idx);
    case (idx)
      1:       return 4'd1;
      2:       return 4'd4;
      3:       return 4'd6;
      4:       return 4'd8;
      5:       return 4'd10;
      7:       return 4'd14;
      default: return 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irqmap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busWrEn,
  input  logic [REG_W-1:0] busWrData,
  output logic [REG_W-1:0] ctrlReg,
  output ctrlStrobe_t      strobes
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrlReg <= RESET_VAL;
    else if (busWrEn) ctrlReg <= busWrData & WR_MASK;
  end

  always_comb begin
    strobes.wrStrobe  = busWrEn;
    strobes.wrEnable  = busWrData[EN_BIT];
    strobes.curEnable = ctrlReg[EN_BIT];
  end

  p_bit6_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busWrEn |=> !ctrlReg[6]);
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busWrEn |=> ctrlReg[EN_BIT] == $past(busWrData[EN_BIT]));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busWrEn |=> $stable(ctrlReg));
endmodule

// File: rtl/irq_level_path.sv
module irq_level_path
  import irqmap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcIrq,
  input  ctrlStrobe_t        strobes,
  output logic [NUM_SRC-1:0] pending,
  output logic [NUM_LVL-1:0] levelVec,
  output logic [LVL_W-1:0]   topIdx
);
  logic [NUM_SRC-1:0] validMask;
  logic [NUM_LVL-1:0] levelNext;
  logic [LVL_W-1:0]   topNext;
  logic               enableNext;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gen_mask
    assign validMask[g] = (srcLevel(g) != '0);
  end

  assign enableNext = strobes.wrStrobe ? strobes.wrEnable : strobes.curEnable;

  always_comb begin
    levelNext = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (validMask[i] && srcIrq[i] && enableNext)
        levelNext[srcLevel(i)] = 1'b1;
    topNext = '0;
    for (int j = 0; j < NUM_LVL; j++)
      if (levelNext[j]) topNext = LVL_W'(j);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= '0;
      levelVec <= '0;
      topIdx   <= '0;
    end else begin
      pending  <= srcIrq & validMask;
      levelVec <= levelNext;
      topIdx   <= topNext;
    end
  end

  p_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pending[0] && !pending[6] && !levelVec[0]);
  p_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    srcIrq[7] |=> pending[7]);
  p_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enableNext |=> (levelVec == '0) && (topIdx == '0));
  p_top_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (levelVec == '0) |-> (topIdx == '0));
  p_top_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (levelVec != '0) |-> levelVec[topIdx]);
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import irqmap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  srcIrq,
  input  logic        busWrEn,
  input  logic [7:0]  busWrData,
  output logic [7:0]  busRdData,
  output logic [7:0]  pendStatus,
  output logic [15:0] levelOut,
  output logic [3:0]  topLevel
);
  ctrlStrobe_t strobes;

  irq_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .ctrlReg   (busRdData),
    .strobes   (strobes)
  );

  irq_level_path u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .srcIrq   (srcIrq),
    .strobes  (strobes),
    .pending  (pendStatus),
    .levelVec (levelOut),
    .topIdx   (topLevel)
  );
endmodule

// File: tb/tb_lvl_irq_ctrl.sv
`timescale 1ns/1ps
module tb_lvl_irq_ctrl;
  localparam real CYC = 20.0;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] srcIrq = '0, busWrData = '0;
  logic busWrEn = 1'b0;
  logic [7:0] busRdData, pendStatus;
  logic [15:0] levelOut;
  logic [3:0] topLevel;
  int checks = 0, errors = 0;

  always #(CYC/2) clk = ~clk;

  lvl_irq_ctrl dut (.*);

  // {sources, expected level vector, expected top index}
  localparam int NV = 13;
  localparam logic [27:0] VEC [NV] = '{
    {8'h00, 16'h0000, 4'd0},  {8'h01, 16'h0000, 4'd0},
    {8'h02, 16'h0002, 4'd1},  {8'h04, 16'h0010, 4'd4},
    {8'h08, 16'h0040, 4'd6},  {8'h10, 16'h0100, 4'd8},
    {8'h20, 16'h0400, 4'd10}, {8'h40, 16'h0000, 4'd0},
    {8'h80, 16'h4000, 4'd14}, {8'hFF, 16'h4552, 4'd14},
    {8'h2A, 16'h0442, 4'd10}, {8'h14, 16'h0110, 4'd8},
    {8'h41, 16'h0000, 4'd0}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    busWrEn = 1'b1; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  initial begin
    #(CYC * 150000);
    errors++;
    $display("FAIL watchdog R1-all actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", busRdData, 8'h01);
    chk("R1 pend", pendStatus, 8'h00);
    chk("R1 level", levelOut, 16'h0);
    chk("R1 top", topLevel, 4'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R5 R6 R8 table walk
    for (int k = 0; k < NV; k++) begin
      srcIrq = VEC[k][27:20];
      @(negedge clk);
      chk("R3 pend", pendStatus, VEC[k][27:20] & 8'hBE);
      chk("R5 R6 level", levelOut, VEC[k][19:4]);
      chk("R8 top", topLevel, VEC[k][3:0]);
    end

    // R2 write masking
    wr(8'hFF);
    chk("R2 rd ff", busRdData, 8'hBF);
    wr(8'h40);
    chk("R2 rd 40", busRdData, 8'h00);

    // R7 disabled: pending tracks, outputs dark
    srcIrq = 8'hFF;
    @(negedge clk);
    chk("R7 pend", pendStatus, 8'hBE);
    chk("R7 level", levelOut, 16'h0);
    chk("R7 top", topLevel, 4'd0);
    srcIrq = 8'h22;
    @(negedge clk);
    chk("R7 pend track", pendStatus, 8'h22);

    // R9 enable write acts at the same edge
    srcIrq = 8'hFF;
    wr(8'h81);
    chk("R9 level", levelOut, 16'h4552);
    chk("R9 rd", busRdData, 8'h81);
    chk("R8 top", topLevel, 4'd14);
    // R9 disable write darkens at same edge
    wr(8'h80);
    chk("R9 dark", levelOut, 16'h0);
    chk("R9 top dark", topLevel, 4'd0);

    // R3 release clears pending
    wr(8'h01);
    srcIrq = 8'h00;
    @(negedge clk);
    chk("R3 clear", pendStatus, 8'h00);
    chk("R6 clear", levelOut, 16'h0);

    // R4 ignored sources alone
    srcIrq = 8'h41;
    @(negedge clk);
    chk("R4 pend", pendStatus, 8'h00);
    chk("R4 level", levelOut, 16'h0);

    // R1 reset mid-operation
    srcIrq = 8'h80; wr(8'h3F);
    rst_n = 1'b0;
    #1;
    chk("R1 re ctrl", busRdData, 8'h01);
    chk("R1 re level", levelOut, 16'h0);
    chk("R1 re pend", pendStatus, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule